// File: doc/BRIEF.md
# Radio Byte FIFO Pair with Level-Threshold Interrupts

This block holds two byte queues between a host register port and a radio data path. One queue carries bytes from the host to the radio (transmit) and the other carries bytes from the radio to the host (receive). Each queue keeps a fill level and watches it against programmable 6-bit thresholds. When the level moves across a threshold, the block records a sticky status bit. A status bit pulls the shared active-low interrupt line only if its enable bit is set.

The host writes transmit bytes, reads receive bytes, programs the thresholds and the enable mask, and reads the status word through a single-cycle register port. Read data appears one cycle after the read strobe. The radio side takes transmit bytes with a pop strobe and gets the byte one cycle later. It delivers receive bytes with a push strobe. Either queue can be flushed on its own through a control register.

Top module: `radio_fifo_pair`

## Requirements
- R1: Register map, by `reg_addr`: 0 transmit data (write pushes), 1 receive data (read pops), 2 control, 3 transmit almost-full threshold, 4 transmit almost-empty threshold, 5 receive almost-full threshold, 6 status, 7 interrupt enable, 8 transmit level, 9 receive level. After reset the thresholds read 0x37, 0x04 and 0x37, status and enable read 0, both levels read 0, and `irq_n` is high.
- R2: Bytes written to register 0 leave on `tx_data` in write order. Each byte is valid one cycle after the `tx_pop` strobe that takes it. Register 8 reports the number held.
- R3: Bytes pushed with `rx_push` are returned by reads of register 1 in arrival order. Register 9 reports the number held.
- R4: Status bit 0 sets when the transmit level goes from at or below the almost-full threshold to above it. It sets once for each crossing and does not set again while the level stays above.
- R5: Status bit 1 sets when the transmit level goes from at or above the almost-empty threshold to below it.
- R6: Status bit 2 sets when the receive level goes from at or below its almost-full threshold to above it.
- R7: A host write to a full transmit queue, or a `tx_pop` on an empty one, is dropped without changing that queue and sets status bit 3. An `rx_push` to a full receive queue, or a host read of an empty one, is dropped in the same way and sets status bit 4. Each queue holds 64 bytes.
- R8: Writing control bit 0 flushes the transmit queue to level 0, and writing control bit 1 flushes the receive queue. Flushing one queue leaves the other unchanged.
- R9: Status bits stay set until the host reads register 6. That read returns the bits and clears them.
- R10: `irq_n` is low exactly when some status bit is set and its bit in the enable register (same bit positions) is set. A masked source still sets its status bit.
- R11: Threshold registers keep only their low 6 bits, and bits 7:6 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after `reg_rd` |
| tx_pop | input | 1 | Radio takes one transmit byte |
| tx_data | output | 8 | Transmit byte, valid the cycle after `tx_pop` |
| tx_empty | output | 1 | Transmit queue holds nothing |
| rx_push | input | 1 | Radio delivers one receive byte |
| rx_data | input | 8 | Receive byte accompanying `rx_push` |
| rx_full | output | 1 | Receive queue holds 64 bytes |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit data, a depth of 64 and 6-bit thresholds. A depth of 64 lets the bench fill each queue completely in a few hundred cycles, so both overflow paths and a drain from full are reachable. Lowering the transmit almost-full threshold to 2 brings the rising crossing within a few writes. The default almost-empty value of 4 makes the falling crossing, and the crossing caused by a flush, happen during short bursts.

// File: rtl/radio_fifo_pkg.sv
package radio_fifo_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_TXDATA = 4'd0;
  localparam logic [ADDR_W-1:0] A_RXDATA = 4'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd2;
  localparam logic [ADDR_W-1:0] A_TXAF   = 4'd3;
  localparam logic [ADDR_W-1:0] A_TXAE   = 4'd4;
  localparam logic [ADDR_W-1:0] A_RXAF   = 4'd5;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd6;
  localparam logic [ADDR_W-1:0] A_EN     = 4'd7;
  localparam logic [ADDR_W-1:0] A_TXLVL  = 4'd8;
  localparam logic [ADDR_W-1:0] A_RXLVL  = 4'd9;

  localparam int N_SRC    = 5;
  localparam int ST_TXAF  = 0;
  localparam int ST_TXAE  = 1;
  localparam int ST_RXAF  = 2;
  localparam int ST_TXERR = 3;
  localparam int ST_RXERR = 4;
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic              push_err,
  output logic              pop_err
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);
  assign do_push  = push && !full && !clr;
  assign do_pop   = pop && !empty && !clr;
  assign push_err = push && full && !clr;
  assign pop_err  = pop && empty && !clr;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (do_pop) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  p_level_bound_r7: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  p_full_push_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> $stable(level));

  p_empty_pop_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !clr) |=> $stable(level));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0));
endmodule

// File: rtl/cross_detect.sv
module cross_detect #(
  parameter int LVL_W  = 7,
  parameter int THR_W  = 6,
  parameter bit RISING = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic [THR_W-1:0] thr,
  output logic             hit
);
  logic [LVL_W-1:0] prev;
  logic [LVL_W-1:0] thr_x;

  assign thr_x = LVL_W'(thr);

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= level;
  end

  generate
    if (RISING) begin : g_up
      assign hit = (prev <= thr_x) && (level > thr_x);
    end else begin : g_down
      assign hit = (prev >= thr_x) && (level < thr_x);
    end
  endgenerate

  p_hit_on_motion_r4: assert property (@(posedge clk) disable iff (rst)
    hit |-> (level != prev));
endmodule

// File: rtl/radio_fifo_pair.sv
module radio_fifo_pair
  import radio_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int THR_W  = 6,
  parameter logic [THR_W-1:0] TXAF_INIT = 6'h37,
  parameter logic [THR_W-1:0] TXAE_INIT = 6'h04,
  parameter logic [THR_W-1:0] RXAF_INIT = 6'h37
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_empty,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              irq_n
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic wr_txd, rd_rxd, wr_ctrl, wr_txaf, wr_txae, wr_rxaf, wr_en, rd_stat;
  logic clr_tx, clr_rx;
  logic tx_full, rx_empty;
  logic tx_push_err, tx_pop_err, rx_push_err, rx_pop_err;
  logic txaf_hit, txae_hit, rxaf_hit;
  logic [LVL_W-1:0]  tx_level, rx_level;
  logic [DATA_W-1:0] rx_dout;
  logic [THR_W-1:0]  thr_txaf, thr_txae, thr_rxaf;
  logic [N_SRC-1:0]  ev, stat_q, stat_d, en_q, en_d;
  logic [DATA_W-1:0] rd_q;
  logic              rx_sel_q;

  assign wr_txd  = reg_wr && (reg_addr == A_TXDATA);
  assign rd_rxd  = reg_rd && (reg_addr == A_RXDATA);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_txaf = reg_wr && (reg_addr == A_TXAF);
  assign wr_txae = reg_wr && (reg_addr == A_TXAE);
  assign wr_rxaf = reg_wr && (reg_addr == A_RXAF);
  assign wr_en   = reg_wr && (reg_addr == A_EN);
  assign rd_stat = reg_rd && (reg_addr == A_STAT);
  assign clr_tx  = wr_ctrl && reg_wdata[0];
  assign clr_rx  = wr_ctrl && reg_wdata[1];

  fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(clr_tx),
    .push(wr_txd), .din(reg_wdata),
    .pop(tx_pop), .dout(tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .push_err(tx_push_err), .pop_err(tx_pop_err)
  );

  fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(clr_rx),
    .push(rx_push), .din(rx_data),
    .pop(rd_rxd), .dout(rx_dout),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .push_err(rx_push_err), .pop_err(rx_pop_err)
  );

  cross_detect #(.LVL_W(LVL_W), .THR_W(THR_W), .RISING(1'b1)) u_txaf (
    .clk(clk), .rst(rst), .level(tx_level), .thr(thr_txaf), .hit(txaf_hit));
  cross_detect #(.LVL_W(LVL_W), .THR_W(THR_W), .RISING(1'b0)) u_txae (
    .clk(clk), .rst(rst), .level(tx_level), .thr(thr_txae), .hit(txae_hit));
  cross_detect #(.LVL_W(LVL_W), .THR_W(THR_W), .RISING(1'b1)) u_rxaf (
    .clk(clk), .rst(rst), .level(rx_level), .thr(thr_rxaf), .hit(rxaf_hit));

  always_comb begin
    ev           = '0;
    ev[ST_TXAF]  = txaf_hit;
    ev[ST_TXAE]  = txae_hit;
    ev[ST_RXAF]  = rxaf_hit;
    ev[ST_TXERR] = tx_push_err || tx_pop_err;
    ev[ST_RXERR] = rx_push_err || rx_pop_err;
  end

  // a new event in the same cycle as a status read survives the clear
  assign stat_d = (rd_stat ? '0 : stat_q) | ev;
  assign en_d   = wr_en ? reg_wdata[N_SRC-1:0] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_txaf <= TXAF_INIT;
      thr_txae <= TXAE_INIT;
      thr_rxaf <= RXAF_INIT;
      stat_q   <= '0;
      en_q     <= '0;
      irq_n    <= 1'b1;
    end else begin
      if (wr_txaf) thr_txaf <= reg_wdata[THR_W-1:0];
      if (wr_txae) thr_txae <= reg_wdata[THR_W-1:0];
      if (wr_rxaf) thr_rxaf <= reg_wdata[THR_W-1:0];
      stat_q <= stat_d;
      en_q   <= en_d;
      irq_n  <= ~|(stat_d & en_d);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= '0;
      rx_sel_q <= 1'b0;
    end else if (reg_rd) begin
      rx_sel_q <= (reg_addr == A_RXDATA);
      case (reg_addr)
        A_TXAF:  rd_q <= DATA_W'(thr_txaf);
        A_TXAE:  rd_q <= DATA_W'(thr_txae);
        A_RXAF:  rd_q <= DATA_W'(thr_rxaf);
        A_STAT:  rd_q <= DATA_W'(stat_q);
        A_EN:    rd_q <= DATA_W'(en_q);
        A_TXLVL: rd_q <= DATA_W'(tx_level);
        A_RXLVL: rd_q <= DATA_W'(rx_level);
        default: rd_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rx_sel_q ? rx_dout : rd_q;

  p_irq_matches_mask_r10: assert property (@(posedge clk) disable iff (rst)
    irq_n == ((stat_q & en_q) == '0));

  p_status_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_stat |=> (($past(stat_q) & ~stat_q) == '0));

  p_rxaf_latched_r6: assert property (@(posedge clk) disable iff (rst)
    rxaf_hit |=> stat_q[ST_RXAF]);

  p_txerr_latched_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_push_err || tx_pop_err) |=> stat_q[ST_TXERR]);

  p_thr_reserved_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr == A_TXAF || reg_addr == A_TXAE || reg_addr == A_RXAF))
      |=> (reg_rdata[DATA_W-1:THR_W] == '0));

  p_no_rx_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full && !rd_rxd && !clr_rx) |=> rx_full);
endmodule

// File: tb/radio_fifo_pair_tb.sv
module radio_fifo_pair_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx_pop = 1'b0;
  logic [7:0] tx_data;
  logic       tx_empty;
  logic       rx_push = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_full;
  logic       irq_n;

  int errors = 0;
  int checks = 0;

  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  logic [5:0] m_taf = 6'h37, m_tae = 6'h04, m_raf = 6'h37;
  logic [4:0] m_stat = '0, m_en = '0;

  radio_fifo_pair u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty),
    .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_eq(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic note_tx(int old_l, int new_l);
    if (old_l <= m_taf && new_l > m_taf) m_stat[0] = 1'b1;
    if (old_l >= m_tae && new_l < m_tae) m_stat[1] = 1'b1;
  endtask

  task automatic note_rx(int old_l, int new_l);
    if (old_l <= m_raf && new_l > m_raf) m_stat[2] = 1'b1;
  endtask

  // scoreboard monitor: compares produced bytes with queued expectations
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (tx_pop && tx_q.size() > 0) begin
        logic [7:0] e;
        e = tx_q.pop_front();
        check_eq("R2 tx byte order", tx_data, e);
      end
      if (reg_rd && reg_addr == 4'd1 && rx_q.size() > 0) begin
        logic [7:0] e;
        e = rx_q.pop_front();
        check_eq("R3 rx byte order", reg_rdata, e);
      end
    end
  end

  task automatic reg_write(logic [3:0] a, logic [7:0] d);
    int old_l;
    old_l = tx_q.size();
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      4'd0: if (old_l >= DEPTH) m_stat[3] = 1'b1;
            else begin tx_q.push_back(d); note_tx(old_l, old_l + 1); end
      4'd2: begin
        if (d[0]) begin tx_q.delete(); note_tx(old_l, 0); end
        if (d[1]) begin note_rx(rx_q.size(), 0); rx_q.delete(); end
      end
      4'd3: m_taf = d[5:0];
      4'd4: m_tae = d[5:0];
      4'd5: m_raf = d[5:0];
      4'd7: m_en = d[4:0];
      default: ;
    endcase
  endtask

  task automatic reg_read(logic [3:0] a, output logic [7:0] d);
    int old_l;
    old_l = rx_q.size();
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
    if (a == 4'd1) begin
      if (old_l == 0) m_stat[4] = 1'b1;
      else note_rx(old_l, rx_q.size());
    end
    if (a == 4'd6) m_stat = '0;
  endtask

  task automatic check_reg(string tag, logic [3:0] a, logic [7:0] exp);
    logic [7:0] d;
    reg_read(a, d);
    check_eq(tag, d, exp);
  endtask

  task automatic check_status(string tag);
    logic [7:0] exp;
    exp = {3'b000, m_stat};
    check_reg(tag, 4'd6, exp);
  endtask

  task automatic radio_pop();
    int old_l;
    old_l = tx_q.size();
    @(negedge clk);
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
    if (old_l == 0) m_stat[3] = 1'b1;
    else note_tx(old_l, tx_q.size());
  endtask

  task automatic radio_push(logic [7:0] d);
    int old_l;
    old_l = rx_q.size();
    @(negedge clk);
    rx_push = 1'b1; rx_data = d;
    @(negedge clk);
    rx_push = 1'b0;
    if (old_l >= DEPTH) m_stat[4] = 1'b1;
    else begin rx_q.push_back(d); note_rx(old_l, old_l + 1); end
  endtask

  task automatic check_irq(string tag);
    @(negedge clk);
    check_eq(tag, {7'd0, irq_n}, {7'd0, ((m_stat & m_en) == '0)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_reg("R1 txaf reset", 4'd3, 8'h37);
    check_reg("R1 txae reset", 4'd4, 8'h04);
    check_reg("R1 rxaf reset", 4'd5, 8'h37);
    check_reg("R1 status reset", 4'd6, 8'h00);
    check_reg("R1 enable reset", 4'd7, 8'h00);
    check_reg("R1 tx level reset", 4'd8, 8'h00);
    check_reg("R1 rx level reset", 4'd9, 8'h00);
    check_eq("R1 irq_n reset", {7'd0, irq_n}, 8'h01);

    // R11 reserved threshold bits
    reg_write(4'd3, 8'hFF);
    check_reg("R11 txaf upper bits", 4'd3, 8'h3F);
    reg_write(4'd5, 8'hC5);
    check_reg("R11 rxaf upper bits", 4'd5, 8'h05);
    reg_write(4'd3, 8'h37);
    reg_write(4'd5, 8'h37);

    // R2 / R5 transmit path and almost-empty crossing
    for (int i = 0; i < 5; i++) reg_write(4'd0, 8'hA0 + 8'(i));
    check_reg("R2 tx level", 4'd8, 8'd5);
    radio_pop(); radio_pop();
    check_status("R5 almost-empty crossing");
    for (int i = 0; i < 3; i++) radio_pop();
    check_eq("R2 tx_empty after drain", {7'd0, tx_empty}, 8'h01);
    radio_pop();
    check_status("R7 pop of empty tx");

    // R4 / R9 / R10 almost-full with interrupt enabled
    reg_write(4'd7, 8'h01);
    reg_write(4'd3, 8'h02);
    for (int i = 0; i < 3; i++) reg_write(4'd0, 8'h10 + 8'(i));
    check_irq("R10 irq asserted on enabled source");
    check_eq("R4 model expects bit0", {3'b0, m_stat}, 8'h01);
    check_status("R4 almost-full crossing");
    check_irq("R9 irq released after status read");
    reg_write(4'd0, 8'h13);
    check_status("R4 no repeat above threshold");
    reg_write(4'd2, 8'h01);
    check_reg("R8 tx flushed", 4'd8, 8'h00);
    check_irq("R10 masked source keeps irq high");
    check_status("R10 masked source still latched");

    // R3 / R6 / R7 receive path to full
    for (int i = 0; i < DEPTH; i++) radio_push(8'(i * 3 + 1));
    check_eq("R7 rx_full", {7'd0, rx_full}, 8'h01);
    radio_push(8'hEE);
    check_reg("R7 rx level held at 64", 4'd9, 8'd64);
    check_status("R6 rx almost-full and overflow");
    for (int i = 0; i < 3; i++) begin
      logic [7:0] d;
      reg_read(4'd1, d);
    end
    reg_write(4'd0, 8'h55);
    reg_write(4'd0, 8'h66);
    reg_write(4'd2, 8'h02);
    check_reg("R8 rx flushed", 4'd9, 8'h00);
    check_reg("R8 tx untouched by rx flush", 4'd8, 8'h02);
    begin
      logic [7:0] d;
      reg_read(4'd1, d);
    end
    check_status("R7 read of empty rx");

    // R7 transmit overflow, then drain from full
    reg_write(4'd7, 8'h18);
    for (int i = 0; i < DEPTH - 2; i++) reg_write(4'd0, 8'(i ^ 8'h5A));
    reg_write(4'd0, 8'hFF);
    check_reg("R7 tx level held at 64", 4'd8, 8'd64);
    check_irq("R10 error source enabled");
    check_status("R7 tx overflow and crossing");
    for (int i = 0; i < DEPTH; i++) radio_pop();
    check_eq("R2 tx_empty after full drain", {7'd0, tx_empty}, 8'h01);
    check_status("R5 crossing on drain");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule